// File: doc/BRIEF.md
# Serial Configuration Port with Register Readback

This block is a three-wire configuration port for a small bank of 16-bit control registers. An external controller frames each transfer by pulling the active-low select low and then clocking 24 bits on the data input, most significant bit first. The first 8 bits carry a register address and the last 16 carry the value to write. Every register clears to zero on reset and is presented in parallel on a flat output bus, so the datapath it configures can use the values directly.

For diagnostics the controller can turn on a readback mode by setting a control bit. While that mode is on, the serial data output is enabled. In each frame, once the 8 address bits are in, the addressed register is shifted out on the output. New values go out on SCLK falling edges, so the controller can capture them on rising edges. While readback is on, every register except the control register is write-protected, and the control register reads back as zero. Clearing the control bit ends readback, lifts the write protection and disables the output again.

The serial pins are sampled by the block's own clock through synchronizers. SCLK must therefore run well below that clock.

Top module: `cfg_serial_port`

## Requirements
- R1: While reset is held and on the cycle after it, every register reads zero, `sdout_oe` is 0 and `sdout` is 0.
- R2: A frame is the interval with `sen_n` low. Bits are taken on SCLK rising edges, MSB first: address[7:0] first, then data[15:0]. When `sen_n` rises after exactly 24 bits and writing is allowed, the data goes into the addressed register and shows on `regs_flat[16*a +: 16]`.
- R3: A frame with fewer or more than 24 SCLK rising edges changes no register.
- R4: Addresses at or above DEPTH (16 by default) are not stored on write and read back as zero.
- R5: Writing a value with bit 0 set to address 0x01 turns readback mode on. `sdout_oe` is 1 exactly while that bit of register 0x01 is 1.
- R6: While readback mode is on, writes to any address other than 0x01 are ignored.
- R7: In readback mode, the addressed register's bits D15..D0 appear on `sdout`. Each bit is updated after an SCLK falling edge and is valid at the 9th through 24th rising edges of the frame, in that order.
- R8: In readback mode, a read of address 0x01 returns all zeros.
- R9: Writing 0x01 with bit 0 clear leaves readback mode. `sdout_oe` then drops and writes to all addresses work again.
- R10: `sdout` is 0 whenever `sdout_oe` is 0, and it is 0 during the address phase of every frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock; it samples the serial pins |
| rst | input | 1 | Synchronous active-high reset |
| sen_n | input | 1 | Frame select, active low |
| sclk | input | 1 | Serial clock from the controller |
| sdin | input | 1 | Serial data in, MSB first |
| sdout | output | 1 | Serial readback data |
| sdout_oe | output | 1 | Output enable for the readback driver (1 drives the pin) |
| regs_flat | output | DEPTH*16 | All registers, register k at bits [16k+15:16k] |

## Verification
A wrong bit count shows up within one frame. Short frames would commit, or good frames would be dropped, and the parallel register bus would then differ from the reference within a few clocks of the select rising. A wrong protection flag shows up at once on `sdout_oe`. It also lets a protected register change at the end of the next frame. A slip in the output shift register moves every readback word by one bit position, so the first non-symmetric word read after entering readback exposes it.

// File: rtl/cfg_sp_pkg.sv
package cfg_sp_pkg;
  localparam int ADDR_W  = 8;
  localparam int DATA_W  = 16;
  localparam int FRAME_W = ADDR_W + DATA_W;
endpackage

// File: rtl/cfg_sp_sync.sv
module cfg_sp_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/cfg_sp_frame.sv
module cfg_sp_frame
  import cfg_sp_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              sen_q,
  input  logic              sclk_q,
  input  logic              sdin_q,
  output logic              frame_start,
  output logic              frame_end,
  output logic              sclk_fall,
  output logic              wr_stb,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              load_stb,
  output logic              shift_stb,
  output logic [ADDR_W-1:0] rd_addr
);
  localparam int CNT_W = $clog2(FRAME_W + 2);
  localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(FRAME_W + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);
  localparam logic [CNT_W-1:0] CNT_ADDR = CNT_W'(ADDR_W);

  logic               sen_prev, sclk_prev, active, sclk_rise;
  logic [CNT_W-1:0]   cnt;
  logic [FRAME_W-1:0] shreg;

  assign active      = ~sen_q;
  assign frame_start = ~sen_q & sen_prev;
  assign frame_end   = sen_q & ~sen_prev;
  assign sclk_rise   = active & sclk_q & ~sclk_prev;
  assign sclk_fall   = active & ~sclk_q & sclk_prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      sen_prev  <= 1'b1;
      sclk_prev <= 1'b0;
      cnt       <= '0;
      shreg     <= '0;
    end else begin
      sen_prev  <= sen_q;
      sclk_prev <= sclk_q;
      if (frame_start) begin
        cnt   <= '0;
        shreg <= '0;
      end else if (sclk_rise) begin
        shreg <= {shreg[FRAME_W-2:0], sdin_q};
        if (cnt != CNT_SAT) cnt <= cnt + 1'b1;
      end
    end
  end

  assign wr_stb    = frame_end && (cnt == CNT_FULL);
  assign wr_addr   = shreg[FRAME_W-1:DATA_W];
  assign wr_data   = shreg[DATA_W-1:0];
  assign load_stb  = sclk_fall && (cnt == CNT_ADDR);
  assign shift_stb = sclk_fall && (cnt > CNT_ADDR);
  assign rd_addr   = shreg[ADDR_W-1:0];
endmodule

// File: rtl/cfg_sp_regfile.sv
module cfg_sp_regfile
  import cfg_sp_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int CTRL_ADDR = 1,
  parameter int RO_BIT = 0
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    wr_stb,
  input  logic [ADDR_W-1:0]       wr_addr,
  input  logic [DATA_W-1:0]       wr_data,
  input  logic [ADDR_W-1:0]       rd_addr,
  output logic [DATA_W-1:0]       rd_data,
  output logic                    readout_on,
  output logic [DEPTH*DATA_W-1:0] regs_flat
);
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DATA_W-1:0] mem [DEPTH];
  logic wr_ok, rd_ok;

  assign readout_on = mem[CTRL_ADDR][RO_BIT];
  assign wr_ok = wr_stb && (int'(wr_addr) < DEPTH) &&
                 (!readout_on || int'(wr_addr) == CTRL_ADDR);
  assign rd_ok = (int'(rd_addr) < DEPTH) && (int'(rd_addr) != CTRL_ADDR);

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (wr_ok) begin
      mem[wr_addr[IDX_W-1:0]] <= wr_data;
    end
  end

  always_comb begin
    rd_data = '0;
    if (rd_ok) rd_data = mem[rd_addr[IDX_W-1:0]];
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_flat
    assign regs_flat[g*DATA_W +: DATA_W] = mem[g];
  end
endmodule

// File: rtl/cfg_sp_readout.sv
module cfg_sp_readout
  import cfg_sp_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              frame_start,
  input  logic              frame_end,
  input  logic              load_stb,
  input  logic              shift_stb,
  input  logic              readout_on,
  input  logic [DATA_W-1:0] rd_data,
  output logic              sdout
);
  logic [DATA_W-1:0] osh;

  always_ff @(posedge clk) begin
    if (rst || frame_start || frame_end) begin
      osh   <= '0;
      sdout <= 1'b0;
    end else if (load_stb && readout_on) begin
      sdout <= rd_data[DATA_W-1];
      osh   <= {rd_data[DATA_W-2:0], 1'b0};
    end else if (shift_stb) begin
      sdout <= osh[DATA_W-1];
      osh   <= {osh[DATA_W-2:0], 1'b0};
    end
  end
endmodule

// File: rtl/cfg_serial_port.sv
module cfg_serial_port
  import cfg_sp_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int CTRL_ADDR = 1,
  parameter int RO_BIT = 0,
  parameter int SYNC_STAGES = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    sen_n,
  input  logic                    sclk,
  input  logic                    sdin,
  output logic                    sdout,
  output logic                    sdout_oe,
  output logic [DEPTH*DATA_W-1:0] regs_flat
);
  logic [2:0]        pins_q;
  logic              frame_start, frame_end, sclk_fall;
  logic              wr_stb, load_stb, shift_stb, readout_on;
  logic [ADDR_W-1:0] wr_addr, rd_addr;
  logic [DATA_W-1:0] wr_data, rd_data;

  cfg_sp_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk(clk), .rst(rst), .d({sen_n, sclk, sdin}), .q(pins_q)
  );

  cfg_sp_frame u_frame (
    .clk(clk), .rst(rst),
    .sen_q(pins_q[2]), .sclk_q(pins_q[1]), .sdin_q(pins_q[0]),
    .frame_start(frame_start), .frame_end(frame_end), .sclk_fall(sclk_fall),
    .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data),
    .load_stb(load_stb), .shift_stb(shift_stb), .rd_addr(rd_addr)
  );

  cfg_sp_regfile #(.DEPTH(DEPTH), .CTRL_ADDR(CTRL_ADDR), .RO_BIT(RO_BIT)) u_regs (
    .clk(clk), .rst(rst), .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .readout_on(readout_on),
    .regs_flat(regs_flat)
  );

  cfg_sp_readout u_out (
    .clk(clk), .rst(rst), .frame_start(frame_start), .frame_end(frame_end),
    .load_stb(load_stb), .shift_stb(shift_stb), .readout_on(readout_on),
    .rd_data(rd_data), .sdout(sdout)
  );

  assign sdout_oe = readout_on;
endmodule

// File: rtl/cfg_serial_port_chk.sv
module cfg_serial_port_chk
  import cfg_sp_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int CTRL_ADDR = 1
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    sdout,
  input logic                    sdout_oe,
  input logic [DEPTH*DATA_W-1:0] regs_flat,
  input logic                    wr_stb,
  input logic [ADDR_W-1:0]       wr_addr,
  input logic                    readout_on,
  input logic                    load_stb,
  input logic [ADDR_W-1:0]       rd_addr,
  input logic                    sclk_fall,
  input logic                    frame_start,
  input logic                    frame_end
);
  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (!sdout_oe && !sdout && regs_flat == '0));

  // R3
  no_commit_chk: assert property (@(posedge clk) disable iff (rst)
    !wr_stb |=> $stable(regs_flat));

  // R6
  locked_write_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_stb && readout_on && int'(wr_addr) != CTRL_ADDR) |=> $stable(regs_flat));

  // R5
  oe_entry_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(sdout_oe) |-> $past(wr_stb && int'(wr_addr) == CTRL_ADDR));

  // R7
  fall_only_chk: assert property (@(posedge clk) disable iff (rst)
    (!sclk_fall && !frame_start && !frame_end) |=> $stable(sdout));

  // R8
  ctrl_hidden_chk: assert property (@(posedge clk) disable iff (rst)
    (load_stb && int'(rd_addr) == CTRL_ADDR) |=> !sdout);

  // R10
  quiet_out_chk: assert property (@(posedge clk) disable iff (rst)
    !sdout_oe |-> !sdout);
endmodule

bind cfg_serial_port cfg_serial_port_chk #(.DEPTH(DEPTH), .CTRL_ADDR(CTRL_ADDR)) u_chk (
  .clk(clk), .rst(rst), .sdout(sdout), .sdout_oe(sdout_oe), .regs_flat(regs_flat),
  .wr_stb(wr_stb), .wr_addr(wr_addr), .readout_on(readout_on),
  .load_stb(load_stb), .rd_addr(rd_addr), .sclk_fall(sclk_fall),
  .frame_start(frame_start), .frame_end(frame_end)
);

// File: tb/cfg_serial_port_bench.sv
module cfg_serial_port_bench;
  localparam int DEPTH = 16;
  localparam int VW = DEPTH * 16;
  localparam int HALF = 8;

  logic clk = 1'b0, rst = 1'b1;
  logic sen_n = 1'b1, sclk = 1'b0, sdin = 1'b0;
  logic sdout, sdout_oe;
  logic [VW-1:0] regs_flat;

  logic [15:0] model [DEPTH];
  bit settled = 1'b0;
  int errors = 0, checks = 0;

  always #10 clk = ~clk;

  cfg_serial_port u_cfg_serial_port (
    .clk(clk), .rst(rst), .sen_n(sen_n), .sclk(sclk), .sdin(sdin),
    .sdout(sdout), .sdout_oe(sdout_oe), .regs_flat(regs_flat)
  );

  function automatic logic [VW-1:0] model_vec();
    logic [VW-1:0] v;
    for (int i = 0; i < DEPTH; i++) v[i*16 +: 16] = model[i];
    return v;
  endfunction

  function automatic bit ro_on();
    return model[1][0];
  endfunction

  task automatic check(input bit ok, input string req, input logic [VW-1:0] act,
                       input logic [VW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // per-clock comparison of register bus and output enable (R2, R5, R6, R9)
  always @(negedge clk) begin
    if (settled) begin
      check(regs_flat == model_vec(), "R2 register bus", regs_flat, model_vec());
      check(sdout_oe == ro_on(), "R5 sdout_oe", VW'(sdout_oe), VW'(ro_on()));
    end
  end

  task automatic frame(input logic [7:0] a, input logic [15:0] d, input int nbits,
                       input string req);
    logic [23:0] word = {a, d};
    logic [15:0] exp_rd, got_rd;
    bit addr_quiet = 1'b1;
    exp_rd = (ro_on() && a < DEPTH && a != 8'h01) ? model[a] : 16'h0;
    got_rd = '0;
    @(negedge clk);
    sen_n = 1'b0;
    repeat (HALF) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      sclk = 1'b0;
      sdin = (i < 24) ? word[23-i] : 1'b0;
      repeat (HALF) @(negedge clk);
      if (i < 8) begin
        if (sdout !== 1'b0) addr_quiet = 1'b0;
      end else if (i < 24) begin
        got_rd[23-i] = sdout;
      end
      sclk = 1'b1;
      repeat (HALF) @(negedge clk);
    end
    sclk = 1'b0;
    repeat (HALF) @(negedge clk);
    settled = 1'b0;
    sen_n = 1'b1;
    repeat (HALF) @(negedge clk);
    check(addr_quiet, "R10 address phase quiet", VW'(!addr_quiet), '0);
    if (nbits == 24) begin
      check(got_rd == exp_rd, req, VW'(got_rd), VW'(exp_rd));
      if (a < DEPTH && (!ro_on() || a == 8'h01)) model[a] = d;
    end
    settled = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < DEPTH; i++) model[i] = '0;
    repeat (4) @(negedge clk);
    // R1 while reset held
    check(regs_flat == '0 && !sdout_oe && !sdout, "R1 reset", regs_flat, '0);
    rst = 1'b0;
    @(negedge clk);
    check(regs_flat == '0 && !sdout_oe && !sdout, "R1 after reset", regs_flat, '0);
    settled = 1'b1;

    frame(8'h03, 16'hA5C3, 24, "R2 write 03 (no readback)");
    frame(8'h00, 16'h1234, 24, "R2 write 00 (no readback)");
    check(regs_flat[3*16 +: 16] == 16'hA5C3, "R2 reg3", VW'(regs_flat[3*16 +: 16]), VW'(16'hA5C3));
    check(regs_flat[15:0] == 16'h1234, "R2 reg0", VW'(regs_flat[15:0]), VW'(16'h1234));

    frame(8'h03, 16'hFFFF, 20, "R3 short frame");
    frame(8'h03, 16'h0000, 28, "R3 long frame");
    check(regs_flat[3*16 +: 16] == 16'hA5C3, "R3 reg3 kept", VW'(regs_flat[3*16 +: 16]), VW'(16'hA5C3));

    frame(8'h40, 16'hBEEF, 24, "R4 out-of-range write");
    check(regs_flat == model_vec(), "R4 bus unchanged", regs_flat, model_vec());

    frame(8'h01, 16'h0001, 24, "R5 enter readback");
    check(sdout_oe == 1'b1, "R5 oe on", VW'(sdout_oe), VW'(1));

    frame(8'h03, 16'h0000, 24, "R7 read 03 / R6 write blocked");
    check(regs_flat[3*16 +: 16] == 16'hA5C3, "R6 reg3 protected", VW'(regs_flat[3*16 +: 16]), VW'(16'hA5C3));
    frame(8'h00, 16'h5555, 24, "R7 read 00");
    frame(8'h40, 16'h0000, 24, "R4 read out of range");
    frame(8'h01, 16'h0001, 24, "R8 read control register");

    frame(8'h01, 16'h0000, 24, "R8 read control while exiting");
    check(sdout_oe == 1'b0 && sdout == 1'b0, "R9 oe off", VW'({sdout_oe, sdout}), '0);
    frame(8'h03, 16'h0F0F, 24, "R9 write re-enabled");
    check(regs_flat[3*16 +: 16] == 16'h0F0F, "R9 reg3 written", VW'(regs_flat[3*16 +: 16]), VW'(16'h0F0F));

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule